// File: doc/BRIEF.md
# Multi-Write-Port Register Memory with Last-Writer Steering

This block is a shallow memory with several write ports and several read ports, all on one clock. Each write port owns its own storage bank, and each bank is held once for every read port, so every read port has a private copy of every bank it can read from. A small selector table keeps one entry per address. Each entry names the write port that most recently stored to that address. Each read port looks up its address in the table and takes the data from the matching bank copy.

Read data can be combinational (latency 0) or registered (latency 1). A read-during-write mode parameter selects one of two behaviours. In forwarding mode, a read of an address that a write port is storing to in the same cycle returns the incoming data. In the relaxed mode no forwarding logic is built. Two write ports that store to one address in the same cycle give an undefined result. The storage-style parameter accepts a plain-register choice or a block-style choice. Parameter sets that are not legal stop elaboration: a latency other than 0 or 1, or the block-style choice with a latency other than 1. Bank contents are never reset.

Top module: `lvt_multiport_mem`

## Requirements
- R1: When a write port asserts its enable, its data is stored at its address, and a later read of that address on any read port returns it.
- R2: Write ports that are enabled in the same cycle at distinct addresses all store their data.
- R3: A read returns the value from the most recent write to that address, whichever write port made that write.
- R4: Every read port independently returns the data for its own address in the same cycle.
- R5: With latency 0, the read data for a port follows its read address combinationally, within the same cycle.
- R6: With latency 1, the read data for a read address presented in one cycle appears after the next rising clock edge and holds until the following edge.
- R7: In forwarding mode, a read of an address that an enabled write port is storing to in the same cycle returns that write's data. At latency 0 it appears in that cycle, and at latency 1 after the edge.
- R8: A write port with its enable low leaves the memory unchanged, whatever address and data it carries.
- R9: Reset points every selector entry at write port 0 and clears the registered read data to zero. Bank contents are kept, so an address last written through port 0 before reset still reads its value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous active-high reset of the selector table and read registers |
| wr_en | input | WR_PORTS | Per-write-port enable |
| wr_addr | input | WR_PORTS*AW | Write addresses, port w in bits [w*AW +: AW] |
| wr_data | input | WR_PORTS*DATA_W | Write data, port w in bits [w*DATA_W +: DATA_W] |
| rd_addr | input | RD_PORTS*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | RD_PORTS*DATA_W | Read data, port r in bits [r*DATA_W +: DATA_W] |

## Verification
A write becomes visible to ordinary reads after the rising edge that captures it. A latency-0 read result is due in the same cycle that its address is applied. A latency-1 result is due one rising edge later. The bench drives both latency variants with identical stimulus on the falling edge. It compares the latency-0 outputs shortly after driving. It holds each latency-1 expectation until the falling edge after the capturing edge, then compares it. Expectations come from a behavioural array that is updated only after the expectations for that cycle have been computed, so forwarded and stored data stay distinct.

// File: rtl/lvt_mem_pkg.sv
package lvt_mem_pkg;

  typedef enum logic {
    RDW_NEW_DATA = 1'b0,
    RDW_ANY      = 1'b1
  } rdw_mode_e;

  typedef enum logic {
    STORE_REGS  = 1'b0,
    STORE_BLOCK = 1'b1
  } store_kind_e;

  // Index width for n selectable items, never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Legal parameter combinations.
  function automatic bit params_legal(input int lat, input store_kind_e kind);
    return ((lat == 0) || (lat == 1)) && !((kind == STORE_BLOCK) && (lat != 1));
  endfunction

endpackage

// File: rtl/lvt_bank.sv
module lvt_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int WP    = 2,
  parameter int RP    = 2,
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int SW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WP-1:0]    wr_en,
  input  logic [WP*AW-1:0] wr_addr,
  input  logic [RP*AW-1:0] rd_addr,
  output logic [RP*SW-1:0] rd_sel,
  output logic [WP-1:0]    wr_solo
);

  logic [SW-1:0] tbl_q [DEPTH];
  logic          tbl_nonzero;

  // Later ports win on a shared address (undefined use anyway).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < DEPTH; a++) tbl_q[a] <= '0;
    end else begin
      for (int p = 0; p < WP; p++) begin
        if (wr_en[p]) tbl_q[wr_addr[p*AW +: AW]] <= SW'(p);
      end
    end
  end

  always_comb begin
    for (int r = 0; r < RP; r++) rd_sel[r*SW +: SW] = tbl_q[rd_addr[r*AW +: AW]];
  end

  // A write is "solo" when no other enabled port targets its address.
  always_comb begin
    for (int p = 0; p < WP; p++) begin
      wr_solo[p] = wr_en[p];
      for (int q = 0; q < WP; q++) begin
        if ((q != p) && wr_en[q] && (wr_addr[q*AW +: AW] == wr_addr[p*AW +: AW]))
          wr_solo[p] = 1'b0;
      end
    end
  end

  always_comb begin
    tbl_nonzero = 1'b0;
    for (int a = 0; a < DEPTH; a++) tbl_nonzero = tbl_nonzero | (|tbl_q[a]);
  end

  AST_TABLE_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tbl_nonzero); // R9

  for (genvar p = 0; p < WP; p++) begin : g_track
    AST_TABLE_TRACKS_WRITER: assert property (@(posedge clk) disable iff (rst)
      wr_solo[p] |=> (tbl_q[$past(wr_addr[p*AW +: AW])] == SW'(p))); // R3
  end

endmodule

// File: rtl/lvt_read_port.sv
module lvt_read_port
  import lvt_mem_pkg::*;
#(
  parameter int        DW     = 16,
  parameter int        WP     = 2,
  parameter int        AW     = 6,
  parameter int        SW     = 1,
  parameter int        RD_LAT = 1,
  parameter rdw_mode_e RDW    = RDW_NEW_DATA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WP*DW-1:0] bank_rd,
  input  logic [SW-1:0]    sel,
  input  logic [AW-1:0]    raddr,
  input  logic [WP-1:0]    wr_en,
  input  logic [WP*AW-1:0] wr_addr,
  input  logic [WP*DW-1:0] wr_data,
  output logic [WP-1:0]    hit,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] steered;
  logic [DW-1:0] resolved;

  always_comb begin
    steered = '0;
    for (int w = 0; w < WP; w++) begin
      if (SW'(w) == sel) steered = bank_rd[w*DW +: DW];
    end
  end

  if (RDW == RDW_NEW_DATA) begin : g_fwd
    always_comb begin
      for (int w = 0; w < WP; w++) hit[w] = wr_en[w] && (wr_addr[w*AW +: AW] == raddr);
    end
  end else begin : g_nofwd
    assign hit = '0;
  end

  always_comb begin
    resolved = steered;
    for (int w = 0; w < WP; w++) begin
      if (hit[w]) resolved = wr_data[w*DW +: DW];
    end
  end

  if (RD_LAT == 0) begin : g_comb
    assign rdata = resolved;
  end else begin : g_reg
    logic [DW-1:0] rdata_q;
    always_ff @(posedge clk) begin
      if (rst) rdata_q <= '0;
      else     rdata_q <= resolved;
    end
    assign rdata = rdata_q;
  end

endmodule

// File: rtl/lvt_multiport_mem.sv
module lvt_multiport_mem
  import lvt_mem_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          DEPTH    = 64,
  parameter int          RD_PORTS = 2,
  parameter int          WR_PORTS = 2,
  parameter int          RD_LAT   = 1,
  parameter rdw_mode_e   RDW      = RDW_NEW_DATA,
  parameter store_kind_e STORE    = STORE_REGS,
  localparam int         AW       = idx_bits(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WR_PORTS-1:0]        wr_en,
  input  logic [WR_PORTS*AW-1:0]     wr_addr,
  input  logic [WR_PORTS*DATA_W-1:0] wr_data,
  input  logic [RD_PORTS*AW-1:0]     rd_addr,
  output logic [RD_PORTS*DATA_W-1:0] rd_data
);

  localparam int SW = idx_bits(WR_PORTS);

  if (!params_legal(RD_LAT, STORE)) begin : g_bad_params
    $error("lvt_multiport_mem: illegal read latency / storage style combination");
  end

  logic [WR_PORTS-1:0][DATA_W-1:0] bank_rd [RD_PORTS];
  logic [RD_PORTS*SW-1:0]          rd_sel;
  logic [WR_PORTS-1:0]             wr_solo;
  logic [WR_PORTS-1:0]             rd_hit [RD_PORTS];

  lvt_table #(
    .WP(WR_PORTS), .RP(RD_PORTS), .DEPTH(DEPTH), .AW(AW), .SW(SW)
  ) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_sel(rd_sel), .wr_solo(wr_solo)
  );

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    for (genvar w = 0; w < WR_PORTS; w++) begin : g_wr
      lvt_bank #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk  (clk),
        .we   (wr_en[w]),
        .waddr(wr_addr[w*AW +: AW]),
        .wdata(wr_data[w*DATA_W +: DATA_W]),
        .raddr(rd_addr[r*AW +: AW]),
        .rdata(bank_rd[r][w])
      );
    end

    lvt_read_port #(
      .DW(DATA_W), .WP(WR_PORTS), .AW(AW), .SW(SW), .RD_LAT(RD_LAT), .RDW(RDW)
    ) u_rport (
      .clk    (clk),
      .rst    (rst),
      .bank_rd(bank_rd[r]),
      .sel    (rd_sel[r*SW +: SW]),
      .raddr  (rd_addr[r*AW +: AW]),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .hit    (rd_hit[r]),
      .rdata  (rd_data[r*DATA_W +: DATA_W])
    );

    for (genvar w = 0; w < WR_PORTS; w++) begin : g_chk
      if (RDW == RDW_NEW_DATA && RD_LAT == 0) begin : g_fwd0
        AST_FORWARD_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
          ($countones(rd_hit[r]) == 1 && rd_hit[r][w])
            |-> (rd_data[r*DATA_W +: DATA_W] == wr_data[w*DATA_W +: DATA_W])); // R7
      end else if (RDW == RDW_NEW_DATA) begin : g_fwd1
        AST_FORWARD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
          ($countones(rd_hit[r]) == 1 && rd_hit[r][w])
            |=> (rd_data[r*DATA_W +: DATA_W] == $past(wr_data[w*DATA_W +: DATA_W]))); // R7
      end
      if (RD_LAT == 0) begin : g_raw
        AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
          wr_solo[w] |=> ((rd_addr[r*AW +: AW] != $past(wr_addr[w*AW +: AW]))
                          || (rd_hit[r] != '0)
                          || (rd_data[r*DATA_W +: DATA_W] == $past(wr_data[w*DATA_W +: DATA_W])))); // R1
      end
    end
  end

endmodule

// File: tb/lvt_multiport_mem_tb_top.sv
`timescale 1ns/1ps
module lvt_multiport_mem_tb_top;
  import lvt_mem_pkg::*;

  localparam int DW    = 16;
  localparam int DEPTH = 64;
  localparam int RP    = 2;
  localparam int WP    = 2;
  localparam int AW    = 6;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [WP-1:0]        wr_en;
  logic [WP*AW-1:0]     wr_addr;
  logic [WP*DW-1:0]     wr_data;
  logic [RP*AW-1:0]     rd_addr;
  logic [RP*DW-1:0]     rd_data_l1;
  logic [RP*DW-1:0]     rd_data_l0;

  always #10 clk = ~clk;

  lvt_multiport_mem #(.DATA_W(DW), .DEPTH(DEPTH), .RD_PORTS(RP), .WR_PORTS(WP),
    .RD_LAT(1), .RDW(RDW_NEW_DATA), .STORE(STORE_REGS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_l1));

  lvt_multiport_mem #(.DATA_W(DW), .DEPTH(DEPTH), .RD_PORTS(RP), .WR_PORTS(WP),
    .RD_LAT(0), .RDW(RDW_NEW_DATA), .STORE(STORE_REGS)) dut_l0_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_l0));

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] ref_mem  [DEPTH];
  bit            ref_known[DEPTH];
  int            ref_last [DEPTH];
  logic [DW-1:0] exp1     [RP];
  bit            exp1_ok  [RP];
  string         exp1_tag [RP];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_wr(int w, bit en, int a, logic [DW-1:0] d);
    wr_en[w] = en;
    wr_addr[w*AW +: AW] = AW'(a);
    wr_data[w*DW +: DW] = d;
  endtask

  task automatic set_rd(int r, int a);
    rd_addr[r*AW +: AW] = AW'(a);
  endtask

  task automatic idle_inputs();
    for (int w = 0; w < WP; w++) set_wr(w, 1'b0, 0, '0);
  endtask

  // Inputs already applied after a falling edge; run one full cycle.
  task automatic step(string tag);
    #1;
    for (int r = 0; r < RP; r++) begin
      int a = int'(rd_addr[r*AW +: AW]);
      bit known = ref_known[a];
      bit fwd = 1'b0;
      logic [DW-1:0] e = ref_mem[a];
      for (int w = 0; w < WP; w++) begin
        if (wr_en[w] && int'(wr_addr[w*AW +: AW]) == a) begin
          e = wr_data[w*DW +: DW]; known = 1'b1; fwd = 1'b1;
        end
      end
      if (known) check(fwd ? "R7 latency0" : $sformatf("R5.%s", tag), rd_data_l0[r*DW +: DW], e);
      exp1[r] = e;
      exp1_ok[r] = known;
      exp1_tag[r] = fwd ? "R7 latency1" : $sformatf("R6.%s", tag);
    end
    for (int w = 0; w < WP; w++) begin
      if (wr_en[w]) begin
        int a = int'(wr_addr[w*AW +: AW]);
        ref_mem[a] = wr_data[w*DW +: DW];
        ref_known[a] = 1'b1;
        ref_last[a] = w;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < RP; r++)
      if (exp1_ok[r]) check(exp1_tag[r], rd_data_l1[r*DW +: DW], exp1[r]);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < RP; r++) check("R9 read register cleared", rd_data_l1[r*DW +: DW], '0);
    rst = 1'b0;
    for (int a = 0; a < DEPTH; a++) if (ref_last[a] != 0) ref_known[a] = 1'b0;
    for (int r = 0; r < RP; r++) exp1_ok[r] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      ref_known[a] = 1'b0; ref_last[a] = 0; ref_mem[a] = '0;
    end
    rst = 1'b1;
    idle_inputs();
    rd_addr = '0;
    @(negedge clk);
    do_reset();

    // R1 / R2: both ports store at distinct addresses in one cycle
    set_wr(0, 1'b1, 3, 16'h1234); set_wr(1, 1'b1, 40, 16'hABCD);
    set_rd(0, 10); set_rd(1, 11);
    step("R2");
    idle_inputs(); set_rd(0, 40); set_rd(1, 3);
    step("R2");
    set_rd(0, 3); set_rd(1, 40);
    step("R1");

    // R8: disabled port carries address and data but must not store
    set_wr(0, 1'b0, 3, 16'h5555); set_wr(1, 1'b0, 40, 16'h6666);
    step("R8");
    idle_inputs(); set_rd(0, 40); set_rd(1, 3);
    step("R8");

    // R3: alternating writers to one address
    set_wr(1, 1'b1, 9, 16'h1111); step("R3");
    idle_inputs(); set_rd(0, 9); set_rd(1, 9); step("R3");
    set_wr(0, 1'b1, 9, 16'h2222); set_rd(0, 3); step("R3");
    idle_inputs(); set_rd(0, 9); step("R3");
    set_wr(1, 1'b1, 9, 16'h3333); step("R3");
    idle_inputs(); step("R3");

    // R4: ports read different addresses in the same cycle
    set_rd(0, 9); set_rd(1, 40); step("R4");
    set_rd(0, 40); set_rd(1, 9); step("R4");

    // R7: forwarding on both read ports, one per write port
    set_wr(0, 1'b1, 12, 16'h0F0F); set_wr(1, 1'b1, 13, 16'hF0F0);
    set_rd(0, 13); set_rd(1, 12); step("R7");
    idle_inputs(); step("R7");

    // R9: contents survive reset when last written via port 0
    set_wr(0, 1'b1, 20, 16'hBEEF); set_wr(1, 1'b1, 21, 16'hCAFE); step("R9");
    idle_inputs();
    do_reset();
    set_rd(0, 20); set_rd(1, 3); step("R9");
    set_rd(0, 21); set_rd(1, 20); step("R9");

    // R1: random traffic, distinct write addresses, reads often forwarded
    for (int i = 0; i < 3000; i++) begin
      int a0 = $urandom_range(0, DEPTH-1);
      int a1 = (a0 + 1 + $urandom_range(0, DEPTH-2)) % DEPTH;
      set_wr(0, 1'($urandom_range(0, 3) != 0), a0, DW'($urandom));
      set_wr(1, 1'($urandom_range(0, 3) != 0), a1, DW'($urandom));
      for (int r = 0; r < RP; r++) begin
        int pick = $urandom_range(0, 3);
        set_rd(r, (pick == 0) ? a0 : (pick == 1) ? a1 : $urandom_range(0, DEPTH-1));
      end
      step("R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule